// File: doc/BRIEF.md
# Byte Staging Buffer for a Serial-Bus Master

This block holds a few bytes between a host register port and the master engine of a two-wire serial bus controller. The host adds a byte by writing the data register, which pulses `host_push`. It removes the oldest byte by reading that register, which pulses `host_pop`; `host_rdata` shows the oldest byte before the pop. The engine talks to the buffer as a whole. After a receive transfer it loads up to `DEPTH` bytes and an entry count in one cycle. For a transmit transfer it reads every slot in parallel on `eng_rbytes` and then sets the entry count to the number of bytes it sent.

The two status flags are sticky. They change only on the boundary events listed below, not on every change in occupancy. An engine load can therefore leave a flag set while the entry count says otherwise, and software that reads the status register sees exactly that.

Host strobes are register accesses and cannot be stalled, so the block applies no back-pressure. A push that finds the buffer full is accepted on the bus and dropped. A pop from an empty buffer returns all ones. Software reads `level` and the flags to pace itself.

Top module: `byte_stage_buf`

## Requirements
- R1: `level` never exceeds `DEPTH`. A `host_push` that arrives when `DEPTH` bytes are held, with no pop in the same cycle, is dropped. The slots and `level` do not change.
- R2: While `level` is 0, `host_rdata` is all ones (0xFF for 8-bit bytes). A pop while empty changes no slot, no flag and not `level`.
- R3: A pop returns the oldest byte, which is slot 0 (bits W-1:0 of `eng_rbytes`). Every remaining byte then moves one slot toward slot 0. The slot at the tail becomes zero.
- R4: `has_data` is set by a push into an empty buffer. It is cleared by a pop that removes the only byte held. No other host operation changes it.
- R5: `full` is set by a push that brings the count to `DEPTH`. It is cleared by a pop made while `DEPTH` bytes are held.
- R6: When a push and a pop arrive in the same cycle, the pop is applied first and the push second. A full buffer therefore accepts the new byte.
- R7: `flush` zeroes every slot, sets `level` to 0 and clears both flags. It takes priority over every other input in that cycle.
- R8: `eng_load` with `eng_recv`=1 and count N first limits N to at most `DEPTH`. It then writes slots 0..N-1 from lanes 0..N-1 of `eng_wbytes`, where lane i is bits 8i+7:8i for 8-bit bytes, and leaves the other slots as they were. It sets `level` to N. It sets `has_data` if N≥1 and sets `full` if N=`DEPTH`, and otherwise leaves both flags unchanged. Host strobes are ignored in that cycle.
- R9: `eng_load` with `eng_recv`=0 sets `level` to the limited count. Slots and flags are unchanged, and host strobes are ignored in that cycle.
- R10: Reset leaves every slot zero, `level` at 0 and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_push | input | 1 | Host write strobe for the data register |
| host_wdata | input | W | Byte written by the host |
| host_pop | input | 1 | Host read strobe for the data register |
| host_rdata | output | W | Oldest byte, or all ones when empty |
| flush | input | 1 | Empties and zeroes the buffer |
| eng_load | input | 1 | Engine count/data load strobe |
| eng_recv | input | 1 | 1: receive load with data; 0: transmit count only |
| eng_count | input | CW | Entry count for the engine load |
| eng_wbytes | input | DEPTH*W | Received bytes, lane i for slot i |
| eng_rbytes | output | DEPTH*W | All slots in parallel, slot i in lane i |
| level | output | CW | Number of bytes held |
| has_data | output | 1 | Sticky "has data" flag |
| full | output | 1 | Sticky "full" flag |

## Verification
The bench uses the default build, with `DEPTH` = 4 and `W` = 8. With so few slots, every boundary is only a few operations away: pushes and pops at zero, one, three and four entries, simultaneous push and pop at both ends, and flag states left behind by engine loads. The 3-bit count port can carry the values 5 to 7, so the limiting in R8 and R9 is exercised directly.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic [1:0] {
    MODE_HOST  = 2'd0,
    MODE_FLUSH = 2'd1,
    MODE_RECV  = 2'd2,
    MODE_XMIT  = 2'd3
  } bsb_mode_e;
endpackage

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
  import bsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            eng_load,
  input  logic            eng_recv,
  input  logic [CW-1:0]   eng_count,
  input  logic            host_push,
  input  logic            host_pop,
  output bsb_mode_e       mode,
  output logic            pop_go,
  output logic            push_go,
  output logic [CW-1:0]   mid_level,
  output logic [CW-1:0]   load_level,
  output logic [CW-1:0]   level
);
  localparam logic [CW-1:0] DMAX = CW'(DEPTH);

  logic [CW-1:0] level_q, level_d;

  // Priority: flush, then engine load, then host strobes
  always_comb begin
    if (flush)                   mode = MODE_FLUSH;
    else if (eng_load && eng_recv) mode = MODE_RECV;
    else if (eng_load)           mode = MODE_XMIT;
    else                         mode = MODE_HOST;
  end

  assign load_level = (eng_count > DMAX) ? DMAX : eng_count;

  // Pop is applied before push in the same cycle
  assign pop_go    = (mode == MODE_HOST) && host_pop && (level_q != '0);
  assign mid_level = level_q - CW'(pop_go);
  assign push_go   = (mode == MODE_HOST) && host_push && (mid_level < DMAX);

  always_comb begin
    unique case (mode)
      MODE_FLUSH: level_d = '0;
      MODE_RECV,
      MODE_XMIT:  level_d = load_level;
      default:    level_d = mid_level + CW'(push_go);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/bsb_store.sv
module bsb_store
  import bsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bsb_mode_e          mode,
  input  logic               pop_go,
  input  logic               push_go,
  input  logic [CW-1:0]      mid_level,
  input  logic [CW-1:0]      load_level,
  input  logic [W-1:0]       wdata,
  input  logic [DEPTH*W-1:0] load_bytes,
  output logic [DEPTH*W-1:0] slots
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q, d, shifted;

    // Neighbour toward the tail; the tail slot takes zero
    if (g == DEPTH - 1) begin : g_tail
      assign shifted = pop_go ? '0 : q;
    end else begin : g_body
      assign shifted = pop_go ? slots[(g+1)*W +: W] : q;
    end

    always_comb begin
      unique case (mode)
        MODE_FLUSH: d = '0;
        MODE_RECV:  d = (CW'(g) < load_level) ? load_bytes[g*W +: W] : q;
        MODE_XMIT:  d = q;
        default:    d = (push_go && (mid_level == CW'(g))) ? wdata : shifted;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign slots[g*W +: W] = q;
  end
endmodule

// File: rtl/bsb_flags.sv
module bsb_flags
  import bsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bsb_mode_e     mode,
  input  logic          pop_go,
  input  logic          push_go,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] mid_level,
  input  logic [CW-1:0] load_level,
  output logic          has_data,
  output logic          full
);
  localparam logic [CW-1:0] DMAX = CW'(DEPTH);
  localparam logic [CW-1:0] DTOP = CW'(DEPTH - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic has_q, has_d, full_q, full_d;

  always_comb begin
    has_d  = has_q;
    full_d = full_q;
    unique case (mode)
      MODE_FLUSH: begin
        has_d  = 1'b0;
        full_d = 1'b0;
      end
      MODE_RECV: begin
        if (load_level != '0)  has_d  = 1'b1;
        if (load_level == DMAX) full_d = 1'b1;
      end
      MODE_XMIT: ;
      default: begin
        // pop edge first, push edge second
        if (pop_go && level == ONE)  has_d  = 1'b0;
        if (pop_go && level == DMAX) full_d = 1'b0;
        if (push_go && mid_level == '0)  has_d  = 1'b1;
        if (push_go && mid_level == DTOP) full_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      has_q  <= has_d;
      full_q <= full_d;
    end
  end

  assign has_data = has_q;
  assign full     = full_q;
endmodule

// File: rtl/byte_stage_buf.sv
module byte_stage_buf
  import bsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_push,
  input  logic [W-1:0]       host_wdata,
  input  logic               host_pop,
  output logic [W-1:0]       host_rdata,
  input  logic               flush,
  input  logic               eng_load,
  input  logic               eng_recv,
  input  logic [CW-1:0]      eng_count,
  input  logic [DEPTH*W-1:0] eng_wbytes,
  output logic [DEPTH*W-1:0] eng_rbytes,
  output logic [CW-1:0]      level,
  output logic               has_data,
  output logic               full
);
  bsb_mode_e     mode;
  logic          pop_go, push_go;
  logic [CW-1:0] mid_level, load_level, level_q;

  bsb_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .eng_load(eng_load),
    .eng_recv(eng_recv), .eng_count(eng_count), .host_push(host_push),
    .host_pop(host_pop), .mode(mode), .pop_go(pop_go), .push_go(push_go),
    .mid_level(mid_level), .load_level(load_level), .level(level_q)
  );

  bsb_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pop_go(pop_go),
    .push_go(push_go), .mid_level(mid_level), .load_level(load_level),
    .wdata(host_wdata), .load_bytes(eng_wbytes), .slots(eng_rbytes)
  );

  bsb_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pop_go(pop_go),
    .push_go(push_go), .level(level_q), .mid_level(mid_level),
    .load_level(load_level), .has_data(has_data), .full(full)
  );

  assign level      = level_q;
  assign host_rdata = (level_q == '0) ? {W{1'b1}} : eng_rbytes[W-1:0];
endmodule

// File: rtl/bsb_checker.sv
module bsb_checker #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_push,
  input logic               host_pop,
  input logic [W-1:0]       host_rdata,
  input logic               flush,
  input logic               eng_load,
  input logic [DEPTH*W-1:0] eng_rbytes,
  input logic [CW-1:0]      level,
  input logic               has_data,
  input logic               full
);
  localparam logic [CW-1:0] DMAX = CW'(DEPTH);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DMAX);

  // R1
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == DMAX && host_push && !host_pop && !flush && !eng_load)
      |=> ($stable(level) && $stable(eng_rbytes)));

  // R2
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (host_rdata == {W{1'b1}}));

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && host_pop && !host_push && !flush && !eng_load)
      |=> ($stable(eng_rbytes) && $stable(has_data) && $stable(full) && level == '0));

  // R4
  first_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && host_push && !flush && !eng_load) |=> has_data);

  // R5
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == DMAX && host_pop && !host_push && !flush && !eng_load) |=> !full);

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !has_data && !full && eng_rbytes == '0));
endmodule

bind byte_stage_buf bsb_checker #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_bsb_checker (
  .clk(clk), .rst_n(rst_n), .host_push(host_push), .host_pop(host_pop),
  .host_rdata(host_rdata), .flush(flush), .eng_load(eng_load),
  .eng_rbytes(eng_rbytes), .level(level), .has_data(has_data), .full(full)
);

// File: tb/test_byte_stage_buf.sv
`timescale 1ns/1ps
module test_byte_stage_buf;
  localparam int D  = 4;
  localparam int W  = 8;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_push = 0, host_pop = 0, flush = 0, eng_load = 0, eng_recv = 0;
  logic [W-1:0] host_wdata = '0;
  logic [CW-1:0] eng_count = '0;
  logic [D*W-1:0] eng_wbytes = '0;
  logic [W-1:0] host_rdata;
  logic [D*W-1:0] eng_rbytes;
  logic [CW-1:0] level;
  logic has_data, full;

  always #2 clk = ~clk;

  byte_stage_buf #(.DEPTH(D), .W(W)) i_byte_stage_buf (
    .clk(clk), .rst_n(rst_n), .host_push(host_push), .host_wdata(host_wdata),
    .host_pop(host_pop), .host_rdata(host_rdata), .flush(flush),
    .eng_load(eng_load), .eng_recv(eng_recv), .eng_count(eng_count),
    .eng_wbytes(eng_wbytes), .eng_rbytes(eng_rbytes), .level(level),
    .has_data(has_data), .full(full)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int m_slot [D];
  int m_cnt = 0;
  bit m_has = 0, m_full = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) m_slot[i] = 0;
      m_cnt = 0; m_has = 0; m_full = 0;
    end else if (flush) begin
      for (int i = 0; i < D; i++) m_slot[i] = 0;
      m_cnt = 0; m_has = 0; m_full = 0;
    end else if (eng_load) begin
      int n;
      n = (int'(eng_count) > D) ? D : int'(eng_count);
      if (eng_recv) begin
        for (int i = 0; i < n; i++) m_slot[i] = int'(eng_wbytes[i*W +: W]);
        if (n >= 1) m_has = 1;
        if (n == D) m_full = 1;
      end
      m_cnt = n;
    end else begin
      if (host_pop && m_cnt > 0) begin
        if (m_cnt == 1) m_has = 0;
        if (m_cnt == D) m_full = 0;
        for (int i = 0; i < D - 1; i++) m_slot[i] = m_slot[i+1];
        m_slot[D-1] = 0;
        m_cnt--;
      end
      if (host_push && m_cnt < D) begin
        if (m_cnt == 0) m_has = 1;
        if (m_cnt == D - 1) m_full = 1;
        m_slot[m_cnt] = int'(host_wdata);
        m_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 level", longint'(level), longint'(m_cnt));
      chk("R4 has_data", longint'(has_data), longint'(m_has));
      chk("R5 full", longint'(full), longint'(m_full));
      chk("R2/R3 host_rdata", longint'(host_rdata),
          (m_cnt == 0) ? 64'hFF : longint'(m_slot[0]));
      for (int i = 0; i < D; i++)
        chk("R3 slot", longint'(eng_rbytes[i*W +: W]), longint'(m_slot[i]));
    end
  end

  task automatic cyc(input bit pu, input int wd, input bit po, input bit fl,
                     input bit ld, input bit rc, input int cnt, input logic [D*W-1:0] bytes);
    @(negedge clk);
    #1;
    host_push = pu; host_wdata = W'(wd); host_pop = po; flush = fl;
    eng_load = ld; eng_recv = rc; eng_count = CW'(cnt); eng_wbytes = bytes;
  endtask

  task automatic push(input int wd); cyc(1, wd, 0, 0, 0, 0, 0, '0); endtask
  task automatic pop();              cyc(0, 0, 1, 0, 0, 0, 0, '0); endtask
  task automatic idle();             cyc(0, 0, 0, 0, 0, 0, 0, '0); endtask

  initial begin : watchdog
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 level", longint'(level), 0);
    chk("R10 flags", longint'({has_data, full}), 0);
    chk("R10 slots", longint'(eng_rbytes), 0);
    // R2: empty pops
    pop(); pop(); idle();
    // R4 R5 R1: fill past full
    push(8'h11); push(8'h22); push(8'h33); push(8'h44); push(8'h55); push(8'h66);
    idle();
    // R6: push and pop together while full, then while empty
    cyc(1, 8'h77, 1, 0, 0, 0, 0, '0);
    // R3 R5 R4: drain
    pop(); pop(); pop(); pop(); pop(); idle();
    cyc(1, 8'h88, 1, 0, 0, 0, 0, '0);
    cyc(1, 8'h99, 1, 0, 0, 0, 0, '0);
    // R7: flush beats host strobes
    push(8'hA1); push(8'hA2);
    cyc(1, 8'hBB, 1, 1, 1, 1, 4, 32'hDEADBEEF);
    idle();
    // R8: receive loads, including limiting and sticky flags
    cyc(1, 8'h12, 1, 0, 1, 1, 4, 32'h04030201);
    cyc(0, 0, 0, 0, 1, 1, 2, 32'hF4F3F2F1);
    pop(); pop(); pop(); idle();
    cyc(0, 0, 0, 0, 1, 1, 0, 32'hEEEEEEEE);
    cyc(0, 0, 0, 0, 1, 1, 7, 32'hC4C3C2C1);
    idle();
    // R9: transmit count set keeps slots and flags
    cyc(1, 8'h5A, 1, 0, 1, 0, 1, 32'h0);
    cyc(0, 0, 0, 0, 1, 0, 6, 32'h0);
    cyc(0, 0, 0, 0, 1, 0, 0, 32'h0);
    pop(); push(8'h3C); idle();
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic [D*W-1:0] b;
      r = int'($urandom_range(0, 99));
      b = {$urandom(), $urandom()};
      cyc(r < 45, int'($urandom_range(0, 255)), (r % 3) == 0, r == 99,
          (r >= 93 && r < 99), r[0], int'($urandom_range(0, 7)), b);
    end
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule